// File: doc/BRIEF.md
# Effective Address and Segment Selector

This unit produces the 16-bit operand offset for a segmented 16-bit processor. It also chooses which of the four segment registers qualifies each access. The execution pipeline presents an access class, an addressing-mode code, the base and index register choices with their current values, a displacement with a width flag, and an optional segment-override prefix, together with a request strobe.

One clock later the unit returns the offset, a 2-bit segment-register code and an error flag, all qualified by a valid strobe. Descriptor lookup, limit checking and the physical address add happen downstream.

The offset wraps modulo 2^16. A short displacement is sign-extended before the add. The default segment follows the access class and whether BP serves as the base. An override prefix only has an effect on ordinary data references.

Top module: `ea_seg_unit`

## Requirements
- R1: `out_vld` is high in the cycle after a cycle where `req` was high, and low in the cycle after a cycle where `req` was low. A synchronous `rst` clears `out_vld`.
- R2: Class code 0 (instruction fetch) always yields segment code 1 (CS), whatever the override inputs are.
- R3: Class code 1 (stack push/pop) always yields segment code 2 (SS), whatever the override inputs are.
- R4: Class code 3 (string destination) always yields segment code 0 (ES), whatever the override inputs are.
- R5: Class code 2 (ordinary data) with no override yields SS (2) when the operand uses BP as its base, and DS (3) otherwise. BP is the base in these cases:
  - modes 2, 4 or 5 with `base_sel`=1;
  - mode 1 with `ind_sel`=3.
- R6: Class code 2 with `ovr_en`=1 yields `ovr_seg` as the segment code, including for BP-based operands.
- R7: Mode 0 (direct) gives the displacement alone. With `disp_wide`=0, only `disp[7:0]` is used and it is sign-extended to 16 bits. With `disp_wide`=1, all of `disp` is used.
- R8: Mode 1 (register indirect) gives the value of the register chosen by `ind_sel`: 0=SI, 1=DI, 2=BX, 3=BP.
- R9: Mode 2 (based) gives base + displacement, where `base_sel` 0=BX and 1=BP.
- R10: Mode 3 (indexed) gives index + displacement, where `idx_sel` 0=SI and 1=DI.
- R11: Mode 4 gives base + index. Mode 5 gives base + index + displacement.
- R12: Every offset sum is taken modulo 2^16, so any carry out of bit 15 is lost.
- R13: Mode codes 6 and 7 set `mode_err` and force the offset to zero. Defined modes clear `mode_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe |
| acc_class | input | 2 | Access class code (R2–R5) |
| mode | input | 3 | Addressing-mode code (R7–R13) |
| base_sel | input | 1 | Base choice: 0=BX, 1=BP |
| idx_sel | input | 1 | Index choice: 0=SI, 1=DI |
| ind_sel | input | 2 | Register-indirect choice: 0=SI, 1=DI, 2=BX, 3=BP |
| bx_val | input | 16 | Current BX value |
| bp_val | input | 16 | Current BP value |
| si_val | input | 16 | Current SI value |
| di_val | input | 16 | Current DI value |
| disp | input | 16 | Displacement (low byte only when short) |
| disp_wide | input | 1 | 1 = 16-bit displacement, 0 = 8-bit |
| ovr_en | input | 1 | Segment-override prefix present |
| ovr_seg | input | 2 | Override segment code (ES=0, CS=1, SS=2, DS=3) |
| out_vld | output | 1 | Result valid |
| offset | output | 16 | Effective offset |
| seg | output | 2 | Segment register code |
| mode_err | output | 1 | Undefined mode code seen |

## Verification
The bench targets these corner cases:
- **Wrap-around sums.** A BX of 0xFFFF plus a small displacement must give a small offset. A design that kept a 17th bit or saturated would return the wrong value.
- **Short displacements with bit 7 set.** A design that zero-extended the byte, or used the high byte of `disp`, would be off by 0xFF00.
- **Overrides on fetch, stack and string-destination accesses.** A design that let the prefix through would move those accesses into the wrong segment.
- **BP-based data operands, with and without a prefix.** Missing the BP rule leaves them in DS. Applying it after the override discards the prefix.
- **Undefined mode codes.** A design that let the adder result through would produce a non-zero offset with no error.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_STACK  = 2'd1,
        ACC_DATA   = 2'd2,
        ACC_STRDST = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        MODE_DIRECT   = 3'd0,
        MODE_REGIND   = 3'd1,
        MODE_BASED    = 3'd2,
        MODE_INDEXED  = 3'd3,
        MODE_BIDX     = 3'd4,
        MODE_BIDX_D   = 3'd5,
        MODE_BAD6     = 3'd6,
        MODE_BAD7     = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_e;
endpackage

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8
) (
    input  mode_e           mode,
    input  logic            base_sel,
    input  logic            idx_sel,
    input  logic [1:0]      ind_sel,
    input  logic [AW-1:0]   bx_val,
    input  logic [AW-1:0]   bp_val,
    input  logic [AW-1:0]   si_val,
    input  logic [AW-1:0]   di_val,
    input  logic [AW-1:0]   disp,
    input  logic            disp_wide,
    output logic [AW-1:0]   off,
    output logic            err,
    output logic            uses_bp
);
    localparam int EXT_W = AW - SW;

    logic [AW-1:0] disp_ext;
    logic [AW-1:0] base_v;
    logic [AW-1:0] idx_v;
    logic [AW-1:0] ind_v;

    always_comb begin
        disp_ext = disp_wide ? disp : {{EXT_W{disp[SW-1]}}, disp[SW-1:0]};
        base_v   = base_sel ? bp_val : bx_val;
        idx_v    = idx_sel  ? di_val : si_val;
        unique case (ind_sel)
            2'd0:    ind_v = si_val;
            2'd1:    ind_v = di_val;
            2'd2:    ind_v = bx_val;
            default: ind_v = bp_val;
        endcase
    end

    always_comb begin
        err     = 1'b0;
        uses_bp = 1'b0;
        off     = '0;
        case (mode)
            MODE_DIRECT:  off = disp_ext;
            MODE_REGIND: begin
                off     = ind_v;
                uses_bp = (ind_sel == 2'd3);
            end
            MODE_BASED: begin
                off     = base_v + disp_ext;
                uses_bp = base_sel;
            end
            MODE_INDEXED: off = idx_v + disp_ext;
            MODE_BIDX: begin
                off     = base_v + idx_v;
                uses_bp = base_sel;
            end
            MODE_BIDX_D: begin
                off     = base_v + idx_v + disp_ext;
                uses_bp = base_sel;
            end
            default: begin
                off = '0;
                err = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ea_seg_pick.sv
module ea_seg_pick
    import ea_pkg::*;
(
    input  acc_e        acc,
    input  logic        uses_bp,
    input  logic        ovr_en,
    input  seg_e        ovr_seg,
    output seg_e        seg
);
    always_comb begin
        unique case (acc)
            ACC_FETCH:  seg = SEG_CS;
            ACC_STACK:  seg = SEG_SS;
            ACC_STRDST: seg = SEG_ES;
            default: begin
                if (ovr_en)       seg = ovr_seg;
                else if (uses_bp) seg = SEG_SS;
                else              seg = SEG_DS;
            end
        endcase
    end
endmodule

// File: rtl/ea_seg_unit.sv
module ea_seg_unit
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [1:0]      acc_class,
    input  logic [2:0]      mode,
    input  logic            base_sel,
    input  logic            idx_sel,
    input  logic [1:0]      ind_sel,
    input  logic [AW-1:0]   bx_val,
    input  logic [AW-1:0]   bp_val,
    input  logic [AW-1:0]   si_val,
    input  logic [AW-1:0]   di_val,
    input  logic [AW-1:0]   disp,
    input  logic            disp_wide,
    input  logic            ovr_en,
    input  logic [1:0]      ovr_seg,
    output logic            out_vld,
    output logic [AW-1:0]   offset,
    output logic [1:0]      seg,
    output logic            mode_err
);
    typedef struct packed {
        logic          vld;
        logic          err;
        logic [AW-1:0] off;
        seg_e          seg;
    } res_t;

    res_t          r_d, r_q;
    logic [AW-1:0] calc_off;
    logic          calc_err;
    logic          calc_bp;
    seg_e          pick_seg;

    ea_offset_calc #(.AW(AW), .SW(SW)) u_off (
        .mode      (mode_e'(mode)),
        .base_sel  (base_sel),
        .idx_sel   (idx_sel),
        .ind_sel   (ind_sel),
        .bx_val    (bx_val),
        .bp_val    (bp_val),
        .si_val    (si_val),
        .di_val    (di_val),
        .disp      (disp),
        .disp_wide (disp_wide),
        .off       (calc_off),
        .err       (calc_err),
        .uses_bp   (calc_bp)
    );

    ea_seg_pick u_seg (
        .acc     (acc_e'(acc_class)),
        .uses_bp (calc_bp),
        .ovr_en  (ovr_en),
        .ovr_seg (seg_e'(ovr_seg)),
        .seg     (pick_seg)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = req;
        if (req) begin
            r_d.err = calc_err;
            r_d.off = calc_off;
            r_d.seg = pick_seg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign out_vld  = r_q.vld;
    assign offset   = r_q.off;
    assign seg      = r_q.seg;
    assign mode_err = r_q.err;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> !out_vld);
    a_r1_vld_follows: assert property (@(posedge clk) disable iff (rst)
        req |=> out_vld);
    a_r1_vld_drops: assert property (@(posedge clk) disable iff (rst)
        !req |=> !out_vld);
    // R2
    a_r2_fetch_cs: assert property (@(posedge clk) disable iff (rst)
        (req && acc_class == 2'd0) |=> seg == 2'd1);
    // R3
    a_r3_stack_ss: assert property (@(posedge clk) disable iff (rst)
        (req && acc_class == 2'd1) |=> seg == 2'd2);
    // R4
    a_r4_strdst_es: assert property (@(posedge clk) disable iff (rst)
        (req && acc_class == 2'd3) |=> seg == 2'd0);
    // R5
    a_r5_bp_based_ss: assert property (@(posedge clk) disable iff (rst)
        (req && acc_class == 2'd2 && !ovr_en && mode == 3'd2 && base_sel)
        |=> seg == 2'd2);
    // R6
    a_r6_override: assert property (@(posedge clk) disable iff (rst)
        (req && acc_class == 2'd2 && ovr_en) |=> seg == $past(ovr_seg));
    // R7
    a_r7_direct_wide: assert property (@(posedge clk) disable iff (rst)
        (req && mode == 3'd0 && disp_wide) |=> offset == $past(disp));
    // R13
    a_r13_err_zero: assert property (@(posedge clk) disable iff (rst)
        (out_vld && mode_err) |-> offset == '0);
endmodule

// File: tb/ea_seg_unit_tb.sv
module ea_seg_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [1:0]  acc_class = '0;
    logic [2:0]  mode = '0;
    logic        base_sel = 1'b0, idx_sel = 1'b0;
    logic [1:0]  ind_sel = '0;
    logic [15:0] bx_val = '0, bp_val = '0, si_val = '0, di_val = '0, disp = '0;
    logic        disp_wide = 1'b0, ovr_en = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic        out_vld, mode_err;
    logic [15:0] offset;
    logic [1:0]  seg;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // expected state for the next comparison
    bit          e_chk = 0;
    bit          e_vld;
    int          e_off, e_seg;
    bit          e_err;
    string       e_seg_tag, e_off_tag;

    always #10 clk = ~clk;

    ea_seg_unit u_dut (
        .clk(clk), .rst(rst), .req(req), .acc_class(acc_class), .mode(mode),
        .base_sel(base_sel), .idx_sel(idx_sel), .ind_sel(ind_sel),
        .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val), .di_val(di_val),
        .disp(disp), .disp_wide(disp_wide), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
        .out_vld(out_vld), .offset(offset), .seg(seg), .mode_err(mode_err)
    );

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural model of the requirements
    task automatic predict();
        int d, b, x, r;
        bit bp_base;
        d = disp_wide ? int'(disp) : ((disp[7]) ? int'(disp[7:0]) + 32'hFF00 : int'(disp[7:0]));
        b = base_sel ? int'(bp_val) : int'(bx_val);
        x = idx_sel ? int'(di_val) : int'(si_val);
        case (ind_sel)
            2'd0: r = si_val;
            2'd1: r = di_val;
            2'd2: r = bx_val;
            default: r = bp_val;
        endcase
        e_err = 0;
        bp_base = 0;
        case (mode)
            3'd0: begin e_off = d;         e_off_tag = "R7";  end
            3'd1: begin e_off = r;         e_off_tag = "R8";  bp_base = (ind_sel == 3); end
            3'd2: begin e_off = b + d;     e_off_tag = "R9";  bp_base = base_sel; end
            3'd3: begin e_off = x + d;     e_off_tag = "R10"; end
            3'd4: begin e_off = b + x;     e_off_tag = "R11"; bp_base = base_sel; end
            3'd5: begin e_off = b + x + d; e_off_tag = "R11"; bp_base = base_sel; end
            default: begin e_off = 0; e_err = 1; e_off_tag = "R13"; end
        endcase
        if (e_off > 32'hFFFF) e_off_tag = "R12";
        e_off = e_off % 65536;
        case (acc_class)
            2'd0: begin e_seg = 1; e_seg_tag = "R2"; end
            2'd1: begin e_seg = 2; e_seg_tag = "R3"; end
            2'd3: begin e_seg = 0; e_seg_tag = "R4"; end
            default: begin
                if (ovr_en) begin e_seg = ovr_seg; e_seg_tag = "R6"; end
                else begin e_seg = bp_base ? 2 : 3; e_seg_tag = "R5"; end
            end
        endcase
        e_vld = req;
        e_chk = 1;
    endtask

    // compare every cycle, between edges
    always @(negedge clk) begin
        if (e_chk && !rst) begin
            check("R1 valid", int'(out_vld), int'(e_vld));
            if (e_vld) begin
                check(e_seg_tag, int'(seg), e_seg);
                check(e_off_tag, int'(offset), e_off);
                check("R13 err", int'(mode_err), int'(e_err));
            end
        end
    end

    task automatic drive(bit rq, logic [1:0] ac, logic [2:0] md, bit bs, bit is,
                         logic [1:0] ns, logic [15:0] bx, logic [15:0] bp,
                         logic [15:0] si, logic [15:0] di, logic [15:0] dp,
                         bit dw, bit oe, logic [1:0] os);
        @(negedge clk);
        #1;
        req = rq; acc_class = ac; mode = md; base_sel = bs; idx_sel = is;
        ind_sel = ns; bx_val = bx; bp_val = bp; si_val = si; di_val = di;
        disp = dp; disp_wide = dw; ovr_en = oe; ovr_seg = os;
        predict();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", int'(out_vld), 0);
        @(negedge clk);
        #1 rst = 1'b0;
        // R12 wrap: BX=FFFF + 2
        drive(1, 2, 2, 0, 0, 0, 16'hFFFF, 0, 0, 0, 16'h0002, 1, 0, 0);
        // R7 short displacement sign extension
        drive(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 16'h1280, 0, 0, 0);
        drive(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 16'h127F, 0, 0, 0);
        // R2/R3/R4 override ignored
        drive(1, 0, 2, 1, 0, 0, 1, 2, 3, 4, 5, 1, 1, 3);
        drive(1, 1, 0, 0, 0, 0, 1, 2, 3, 4, 5, 1, 1, 3);
        drive(1, 3, 3, 0, 1, 0, 1, 2, 3, 4, 5, 1, 1, 3);
        // R5 BP base, R6 override over BP
        drive(1, 2, 4, 1, 0, 0, 10, 20, 30, 40, 0, 1, 0, 0);
        drive(1, 2, 1, 0, 0, 3, 10, 20, 30, 40, 0, 1, 0, 0);
        drive(1, 2, 2, 1, 0, 0, 10, 20, 30, 40, 16'h00FF, 0, 1, 0);
        // R13 undefined modes
        drive(1, 2, 6, 0, 0, 0, 10, 20, 30, 40, 50, 1, 0, 0);
        drive(1, 2, 7, 1, 1, 0, 10, 20, 30, 40, 50, 1, 0, 0);
        // R1 idle cycle
        drive(0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 2000; i++) begin
            drive(($urandom % 5) != 0, 2'($urandom), 3'($urandom), 1'($urandom),
                  1'($urandom), 2'($urandom), 16'($urandom), 16'($urandom),
                  16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
                  1'($urandom), 2'($urandom));
        end
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        #1 rst = 1'b1;
        e_chk = 0;
        @(negedge clk);
        check("R1 reset again", int'(out_vld), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule